// File: doc/BRIEF.md
# Single-Channel Word Mover

This block is one channel of a direct-memory-access engine. It copies data words between two addresses without processor help: a fixed or advancing **peripheral-side** address and a fixed or advancing **memory-side** address. Each transfer is a read followed by a write on a simple single-beat bus master port.

Software programs the channel through a small register port. It sets a transfer count and two base addresses, then turns on the enable bit. After that, the channel waits for a request line from a peripheral. In memory-to-memory mode it does not wait and runs on its own. It raises half-transfer, complete and error flags, and these are combined with per-flag enables into one interrupt line.

In circular mode the channel reloads its count and both addresses when the count runs out, so it can keep a ring buffer filled. Without circular mode it parks at zero until the enable is cleared and set again.

Top module: `dma_chan`

## Requirements
- R1: After reset, every register reads as zero, and `bus_req`, `per_ack` and `irq` are low.
- R2: No bus access begins while the enable bit (control bit 0) is 0, whatever `per_req` does.
- R3: Direction bit (control bit 4) selects the source side. With 0, the read uses the peripheral address and the write uses the memory address. With 1, the read uses the memory address and the write uses the peripheral address. The word read is the word written. Address and direction hold steady while a beat waits for `bus_ack`/`bus_err`.
- R4: After each completed read/write pair, the peripheral address advances by 4 if control bit 6 is set, and the memory address advances by 4 if control bit 7 is set. Otherwise each address stays where it is.
- R5: In request mode, each `per_req` yields exactly one transfer. The channel then pulses `per_ack` for one cycle once the write has been accepted.
- R6: With control bit 8 (memory-to-memory) set, transfers run back to back without `per_req` until the count is exhausted, and `per_ack` stays low.
- R7: The remaining count drops by one per completed pair. Status bit 0 (half) sets when the remaining count equals the programmed count shifted right by one. Status bit 1 (complete) sets when it reaches zero.
- R8: Without circular mode, the channel stops at a remaining count of zero with the enable still set. Writing the enable from 0 to 1 reloads the count and both addresses from their programmed values.
- R9: With control bit 5 (circular) set, reaching zero reloads the count and both working addresses from the programmed values, and requests continue to be served.
- R10: A `bus_err` on either beat sets status bit 2 (error), clears the enable bit and skips the rest of that transfer. The remaining count is left unchanged.
- R11: `irq` is high when any status flag is set together with its enable: control bit 1 for complete, bit 2 for half, bit 3 for error. Writing 1 to a status bit clears it.
- R12: Register select: 0 is control (bits 8:0), 1 is count, 2 is peripheral address, 3 is memory address, 4 is status (bits 2:0). Reads of 1 to 3 return the working (live) values. Writes to 1 to 3 set the programmed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq | output | 1 | Channel interrupt |
| per_req | input | 1 | Peripheral transfer request |
| per_ack | output | 1 | One-cycle acknowledge to the peripheral |
| bus_req | output | 1 | Bus beat valid |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | ADDR_W | Beat byte address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Beat accepted |
| bus_err | input | 1 | Beat failed |

## Verification
The bench builds the channel with 32-bit words, a 16-bit address and an 8-bit count. Short counts of 2 to 4 are therefore enough to reach half and complete flags, circular wrap-around and stop-at-zero within a few dozen cycles. A 256-word bench memory decoded from address bits 9:2 covers every address the channel can walk to in those runs. A per-address error injector reaches the error path on the read beat.

// File: rtl/dma_chan_pkg.sv
// Shared types for the single-channel word mover.
// Assumes: control layout below is what software writes at select 0.
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } xfer_state_t;

    // Packed MSB first: en is bit 0, m2m is bit 8.
    typedef struct packed {
        logic m2m;
        logic minc;
        logic pinc;
        logic circ;
        logic dir;
        logic err_ie;
        logic ht_ie;
        logic tc_ie;
        logic en;
    } chan_ctrl_t;

    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_COUNT = 3'd1;
    localparam logic [2:0] SEL_PADDR = 3'd2;
    localparam logic [2:0] SEL_MADDR = 3'd3;
    localparam logic [2:0] SEL_STAT  = 3'd4;

endpackage

// File: rtl/dma_cfg_regs.sv
// Register file of the channel: control, programmed count/addresses and
// the three event flags (write-1-to-clear), plus interrupt combine.
// Assumes: ADDR_W and CNT_W do not exceed DATA_W.
module dma_cfg_regs
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_ht,
    input  logic              ev_tc,
    input  logic              ev_err,
    input  logic [CNT_W-1:0]  work_cnt,
    input  logic [ADDR_W-1:0] work_paddr,
    input  logic [ADDR_W-1:0] work_maddr,
    output chan_ctrl_t        ctrl,
    output logic [CNT_W-1:0]  prog_cnt,
    output logic [ADDR_W-1:0] prog_paddr,
    output logic [ADDR_W-1:0] prog_maddr,
    output logic              load,
    output logic              flag_ht,
    output logic              flag_tc,
    output logic              flag_err,
    output logic              irq
);
    localparam int CTRL_W = $bits(chan_ctrl_t);

    logic wr_ctrl, wr_stat;

    assign wr_ctrl = reg_we && (reg_sel == SEL_CTRL);
    assign wr_stat = reg_we && (reg_sel == SEL_STAT);
    // Enable going 0 -> 1 by software reloads the working state.
    assign load    = wr_ctrl && reg_wdata[0] && !ctrl.en;

    // Control register; a bus error forces the enable low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) ctrl <= chan_ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (ev_err)  ctrl.en <= 1'b0;
        end
    end

    // Programmed count and base addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_cnt   <= '0;
            prog_paddr <= '0;
            prog_maddr <= '0;
        end else if (reg_we) begin
            if (reg_sel == SEL_COUNT) prog_cnt   <= reg_wdata[CNT_W-1:0];
            if (reg_sel == SEL_PADDR) prog_paddr <= reg_wdata[ADDR_W-1:0];
            if (reg_sel == SEL_MADDR) prog_maddr <= reg_wdata[ADDR_W-1:0];
        end
    end

    // Event flags: set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_ht  <= 1'b0;
            flag_tc  <= 1'b0;
            flag_err <= 1'b0;
        end else begin
            flag_ht  <= ev_ht  || (flag_ht  && !(wr_stat && reg_wdata[0]));
            flag_tc  <= ev_tc  || (flag_tc  && !(wr_stat && reg_wdata[1]));
            flag_err <= ev_err || (flag_err && !(wr_stat && reg_wdata[2]));
        end
    end

    // Interrupt combine.
    assign irq = (flag_tc && ctrl.tc_ie) || (flag_ht && ctrl.ht_ie)
              || (flag_err && ctrl.err_ie);

    // Read mux.
    always_comb begin
        case (reg_sel)
            SEL_CTRL:  reg_rdata = DATA_W'(ctrl);
            SEL_COUNT: reg_rdata = DATA_W'(work_cnt);
            SEL_PADDR: reg_rdata = DATA_W'(work_paddr);
            SEL_MADDR: reg_rdata = DATA_W'(work_maddr);
            SEL_STAT:  reg_rdata = DATA_W'({flag_err, flag_tc, flag_ht});
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_xfer_engine.sv
// Transfer sequencer: one read beat, one write beat per item, then a
// settle cycle that carries the peripheral acknowledge. Holds the live
// count and addresses.
// Assumes: bus slave answers each beat with exactly one ack or err pulse.
module dma_xfer_engine
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chan_ctrl_t        ctrl,
    input  logic [CNT_W-1:0]  prog_cnt,
    input  logic [ADDR_W-1:0] prog_paddr,
    input  logic [ADDR_W-1:0] prog_maddr,
    input  logic              load,
    input  logic              per_req,
    output logic              per_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    output logic [CNT_W-1:0]  work_cnt,
    output logic [ADDR_W-1:0] work_paddr,
    output logic [ADDR_W-1:0] work_maddr,
    output logic              ev_ht,
    output logic              ev_tc,
    output logic              ev_err
);
    localparam int               STEP      = DATA_W / 8;
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(STEP);

    xfer_state_t       state;
    logic [DATA_W-1:0] data_q;
    logic              start, wr_done;
    logic [CNT_W-1:0]  cnt_next;
    logic [ADDR_W-1:0] src_addr, dst_addr;

    assign src_addr = ctrl.dir ? work_maddr : work_paddr;
    assign dst_addr = ctrl.dir ? work_paddr : work_maddr;
    assign start    = (state == ST_IDLE) && ctrl.en && (work_cnt != '0)
                   && (ctrl.m2m || per_req) && !load;
    assign wr_done  = (state == ST_WRITE) && bus_ack && !bus_err;
    assign cnt_next = work_cnt - CNT_W'(1);

    assign bus_req   = (state == ST_READ) || (state == ST_WRITE);
    assign bus_we    = (state == ST_WRITE);
    assign bus_addr  = (state == ST_WRITE) ? dst_addr : src_addr;
    assign bus_wdata = data_q;
    assign per_ack   = (state == ST_DONE) && !ctrl.m2m;

    assign ev_err = bus_req && bus_err;
    assign ev_tc  = wr_done && (cnt_next == '0);
    assign ev_ht  = wr_done && (cnt_next == (prog_cnt >> 1));

    // Sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (start) state <= ST_READ;
                ST_READ:  if (bus_err) state <= ST_IDLE;
                          else if (bus_ack) state <= ST_WRITE;
                ST_WRITE: if (bus_err) state <= ST_IDLE;
                          else if (bus_ack) state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Capture the word read on the first beat.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else if ((state == ST_READ) && bus_ack && !bus_err) data_q <= bus_rdata;
    end

    // Live count and addresses: reload on enable or circular wrap, else step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_cnt   <= '0;
            work_paddr <= '0;
            work_maddr <= '0;
        end else if (load || (wr_done && (cnt_next == '0) && ctrl.circ)) begin
            work_cnt   <= prog_cnt;
            work_paddr <= prog_paddr;
            work_maddr <= prog_maddr;
        end else if (wr_done) begin
            work_cnt <= cnt_next;
            if (ctrl.pinc) work_paddr <= work_paddr + ADDR_STEP;
            if (ctrl.minc) work_maddr <= work_maddr + ADDR_STEP;
        end
    end

endmodule

// File: rtl/dma_chan.sv
// Top of the single-channel word mover: joins the register file and the
// transfer sequencer.
// Assumes: one channel, no arbitration; bus is single-beat, in order.
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              per_req,
    output logic              per_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);
    chan_ctrl_t        ctrl;
    logic [CNT_W-1:0]  prog_cnt, work_cnt;
    logic [ADDR_W-1:0] prog_paddr, prog_maddr, work_paddr, work_maddr;
    logic              load, ev_ht, ev_tc, ev_err;
    logic              flag_ht, flag_tc, flag_err;

    dma_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ev_ht(ev_ht), .ev_tc(ev_tc), .ev_err(ev_err),
        .work_cnt(work_cnt), .work_paddr(work_paddr), .work_maddr(work_maddr),
        .ctrl(ctrl), .prog_cnt(prog_cnt),
        .prog_paddr(prog_paddr), .prog_maddr(prog_maddr),
        .load(load),
        .flag_ht(flag_ht), .flag_tc(flag_tc), .flag_err(flag_err),
        .irq(irq)
    );

    dma_xfer_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .ctrl(ctrl), .prog_cnt(prog_cnt),
        .prog_paddr(prog_paddr), .prog_maddr(prog_maddr),
        .load(load),
        .per_req(per_req), .per_ack(per_ack),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err),
        .work_cnt(work_cnt), .work_paddr(work_paddr), .work_maddr(work_maddr),
        .ev_ht(ev_ht), .ev_tc(ev_tc), .ev_err(ev_err)
    );

endmodule

// File: rtl/dma_chan_chk.sv
// Protocol and flag checks for the word mover, bound to its top.
// Assumes: signals sampled at the rising edge, reset synchronous active-low.
module dma_chan_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              bus_err,
    input logic              per_ack,
    input logic              ctrl_en,
    input logic              flag_tc,
    input logic              flag_err
);
    // R2
    idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && !ctrl_en) |=> !bus_req);

    // R3
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !bus_err) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R5
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |=> !per_ack);

    // R10
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_err) |=> (!ctrl_en && flag_err && !bus_req));

    // R7
    tc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_tc) |-> $past(bus_req && bus_we && bus_ack && !bus_err));

endmodule

bind dma_chan dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_ack(bus_ack), .bus_err(bus_err),
    .per_ack(per_ack), .ctrl_en(ctrl.en),
    .flag_tc(flag_tc), .flag_err(flag_err)
);

// File: tb/tb_dma_chan.sv
// Directed bench: one task per scenario, bench memory acts as bus slave.
module tb_dma_chan;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam int CW = 8;

    // Control bit values (R12).
    localparam logic [31:0] C_EN = 32'h001, C_TCIE = 32'h002, C_HTIE = 32'h004,
                            C_ERRIE = 32'h008, C_DIR = 32'h010, C_CIRC = 32'h020,
                            C_PINC = 32'h040, C_MINC = 32'h080, C_M2M = 32'h100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_sel = 3'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq, per_ack, bus_req, bus_we;
    logic          per_req = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ack = 1'b0, bus_err = 1'b0;
    logic [AW-1:0] err_addr = 16'hFFFF;
    logic [31:0]   mem [0:255];
    int            n_run = 0, n_fail = 0;
    logic          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq),
        .per_req(per_req), .per_ack(per_ack),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err)
    );

    // Bus slave model: one-cycle latency, error on a chosen address.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
        end else if (bus_req && !bus_ack && !bus_err) begin
            if (bus_addr == err_addr) begin
                bus_err <= 1'b1;
            end else begin
                bus_ack   <= 1'b1;
                bus_rdata <= mem[bus_addr[9:2]];
                if (bus_we) mem[bus_addr[9:2]] <= bus_wdata;
            end
        end else begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] sel, output logic [31:0] val);
        @(negedge clk);
        reg_sel = sel;
        #1 val = reg_rdata;
    endtask

    // Raise a request, wait for the acknowledge, drop it.
    task automatic pulse_req(output logic got);
        got = 1'b0;
        @(negedge clk);
        per_req = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (per_ack) begin got = 1'b1; break; end
        end
        per_req = 1'b0;
    endtask

    // Count cycles with bus_req high over a window.
    task automatic watch_bus(input int cycles, output int busy, output int acks);
        busy = 0; acks = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (bus_req) busy++;
            if (per_ack) acks++;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int s = 0; s < 5; s++) begin
            reg_rd(3'(s), v);
            chk("R1 reg after reset", v, 32'h0);
        end
        chk("R1 bus_req", {31'b0, bus_req}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 per_ack", {31'b0, per_ack}, 32'h0);
    endtask

    task automatic t_gate;
        logic [31:0] v;
        int busy, acks;
        reg_wr(3'd0, 32'h1FE);
        reg_rd(3'd0, v);
        chk("R12 control readback", v, 32'h1FE);
        reg_wr(3'd0, C_MINC);
        reg_wr(3'd1, 32'd4);
        @(negedge clk) per_req = 1'b1;
        watch_bus(20, busy, acks);
        per_req = 1'b0;
        chk("R2 no beats while disabled", 32'(busy), 32'h0);
        reg_rd(3'd1, v);
        chk("R12 count reads working value", v, 32'h0);
    endtask

    task automatic t_p2m;
        logic [31:0] v;
        logic got;
        int busy, acks;
        mem[132] = 32'hDEAD_0132;
        reg_wr(3'd1, 32'd4);
        reg_wr(3'd2, 32'h0100);
        reg_wr(3'd3, 32'h0200);
        reg_wr(3'd0, C_EN | C_TCIE | C_MINC);
        for (int k = 0; k < 4; k++) begin
            mem[64] = 32'hA000 + 32'(k);
            pulse_req(got);
            chk("R5 acknowledge per request", {31'b0, got}, 32'h1);
            if (k == 1) begin
                reg_rd(3'd4, v);
                chk("R7 half flag at half count", v, 32'h1);
            end
        end
        for (int k = 0; k < 4; k++)
            chk("R3 R4 memory written in order", mem[128+k], 32'hA000 + 32'(k));
        chk("R4 no write past count", mem[132], 32'hDEAD_0132);
        reg_rd(3'd4, v);
        chk("R7 complete flag", v, 32'h3);
        reg_rd(3'd1, v);
        chk("R7 count at zero", v, 32'h0);
        reg_rd(3'd3, v);
        chk("R4 memory address advanced", v, 32'h0210);
        reg_rd(3'd2, v);
        chk("R4 peripheral address held", v, 32'h0100);
        chk("R11 irq from complete", {31'b0, irq}, 32'h1);
        @(negedge clk) per_req = 1'b1;
        watch_bus(20, busy, acks);
        per_req = 1'b0;
        chk("R8 parked at zero", 32'(busy), 32'h0);
        reg_rd(3'd0, v);
        chk("R8 enable stays set", v & C_EN, C_EN);
        reg_wr(3'd4, 32'h7);
        chk("R11 irq after clear", {31'b0, irq}, 32'h0);
        reg_rd(3'd4, v);
        chk("R11 flags cleared", v, 32'h0);
        reg_wr(3'd0, C_MINC);
        reg_wr(3'd0, C_EN | C_MINC);
        reg_rd(3'd1, v);
        chk("R8 re-enable reloads count", v, 32'h4);
        reg_rd(3'd3, v);
        chk("R8 re-enable reloads address", v, 32'h0200);
        reg_wr(3'd0, 32'h0);
    endtask

    task automatic t_m2m;
        logic [31:0] v;
        int busy, acks;
        for (int k = 0; k < 3; k++) mem[192+k] = 32'hC0DE_0000 + 32'(k);
        mem[99] = 32'h5555_0099;
        reg_wr(3'd1, 32'd3);
        reg_wr(3'd2, 32'h0180);
        reg_wr(3'd3, 32'h0300);
        reg_wr(3'd0, C_EN | C_DIR | C_PINC | C_MINC | C_M2M);
        watch_bus(80, busy, acks);
        for (int k = 0; k < 3; k++)
            chk("R6 R3 copied memory to peripheral side", mem[96+k], 32'hC0DE_0000 + 32'(k));
        chk("R6 stops at count", mem[99], 32'h5555_0099);
        chk("R6 no peripheral acknowledge", 32'(acks), 32'h0);
        reg_rd(3'd4, v);
        chk("R7 complete and half after run", v, 32'h3);
        reg_rd(3'd2, v);
        chk("R4 peripheral address advanced", v, 32'h018C);
        reg_wr(3'd0, 32'h0);
        reg_wr(3'd4, 32'h7);
    endtask

    task automatic t_circ;
        logic [31:0] v;
        logic got;
        mem[146] = 32'hBEEF_0146;
        reg_wr(3'd1, 32'd2);
        reg_wr(3'd2, 32'h0100);
        reg_wr(3'd3, 32'h0240);
        reg_wr(3'd0, C_EN | C_MINC | C_CIRC);
        for (int k = 0; k < 3; k++) begin
            mem[64] = 32'hB000 + 32'(k);
            pulse_req(got);
            chk("R9 request served", {31'b0, got}, 32'h1);
        end
        chk("R9 wrapped write to base", mem[144], 32'hB002);
        chk("R9 second slot", mem[145], 32'hB001);
        chk("R9 no write beyond ring", mem[146], 32'hBEEF_0146);
        reg_rd(3'd1, v);
        chk("R9 count reloaded then stepped", v, 32'h1);
        reg_rd(3'd3, v);
        chk("R9 address reloaded then stepped", v, 32'h0244);
        reg_rd(3'd4, v);
        chk("R9 complete flag on wrap", v & 32'h2, 32'h2);
        reg_wr(3'd0, 32'h0);
        reg_wr(3'd4, 32'h7);
    endtask

    task automatic t_err;
        logic [31:0] v;
        logic got;
        mem[160] = 32'h0BAD_0160;
        err_addr = 16'h0100;
        reg_wr(3'd1, 32'd2);
        reg_wr(3'd2, 32'h0100);
        reg_wr(3'd3, 32'h0280);
        reg_wr(3'd0, C_EN | C_ERRIE | C_MINC);
        pulse_req(got);
        chk("R10 no acknowledge on error", {31'b0, got}, 32'h0);
        reg_rd(3'd4, v);
        chk("R10 error flag", v, 32'h4);
        reg_rd(3'd0, v);
        chk("R10 enable cleared", v & C_EN, 32'h0);
        chk("R11 irq from error", {31'b0, irq}, 32'h1);
        chk("R10 write skipped", mem[160], 32'h0BAD_0160);
        reg_rd(3'd1, v);
        chk("R10 count unchanged", v, 32'h2);
        err_addr = 16'hFFFF;
        reg_wr(3'd4, 32'h4);
        chk("R11 irq cleared", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gate();
        t_p2m();
        t_m2m();
        t_circ();
        t_err();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule